// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the frequency, in hertz, that a phase-locked loop delivers for a given control setting. It also works out the peripheral bus clock derived from it. A host pulses `start_i` with three words. The PLL parameter word carries the off, bypass and programming controls and the multiplier and divider fields. The clock-select word carries the bus pre-divider. The strap word chooses the reference crystal frequency and, in legacy mode, a strapped frequency preset. The block decodes these words and runs every division through one shared restoring divider. When both results are ready, it pulses `done_o` with both frequencies on its outputs.

A parameter picks one of two parameter-word layouts. In the current layout, a three-field multiplier and divider chain is decoded. In the legacy layout, a programmed bit chooses between a two-field formula and a preset table indexed by strap bits. Every division truncates, in the order the requirements give, so the result matches integer arithmetic bit for bit. No clock is generated.

Top module: `pll_freq_calc`

## Requirements
- R1: The reference frequency is chosen from the strap word with this priority. Strap bit 23 set gives 25,000,000. Otherwise strap bit 18 set gives 48,000,000. Otherwise it is 24,000,000.
- R2: If the off bit is set in the parameter word, both the PLL output and the bus clock are 0. The off bit is bit 23 in the current layout and bit 18 in the legacy layout. The off bit takes priority over every other control.
- R3: Current layout. If bypass (bit 20) is set, the multiplier is 1. Otherwise the multiplier is ((m+1)/(n+1))/(p+1), with each division truncating. Here p is bits 18:13, m is bits 12:5 and n is bits 4:0.
- R4: Legacy layout, with the programmed bit (bit 19) clear. The PLL output is a preset in MHz multiplied by 1,000,000. Strap bits 9:8 index the preset list 384, 360, 336, 408 (index 0 to 3) when strap bit 23 is clear. They index the list 400, 375, 350, 425 when strap bit 23 is set.
- R5: Legacy layout, with the programmed bit set. If bypass (bit 17) is set, the multiplier is 1. Otherwise the multiplier is (2−od)×((n+2)/(d+1)), with truncating division. Here n is bits 10:5, od is bit 4 and d is bits 3:0.
- R6: Apart from the R2 and R4 cases, the PLL output is the reference frequency times the multiplier, kept to its low 32 bits.
- R7: The bus clock is (PLL output/(k+1))/B, with both divisions truncating. Here k is clock-select bits 25:23. B is 4 in the current layout and 2 in the legacy layout.
- R8: `busy_o` is high from the cycle after an accepted start up to, but not including, the cycle in which `done_o` is high. `done_o` is high for exactly one cycle per accepted start, and never while `busy_o` is high.
- R9: A start pulse while `busy_o` is high is ignored. The running computation finishes with the words that were captured when it was accepted.
- R10: After reset, both outputs are 0 and `busy_o` and `done_o` are low. The outputs change only in a cycle where `done_o` is high.
- R11: A start pulse in the cycle where `done_o` is high is accepted. In that case `busy_o` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a computation (accepted when not busy) |
| param_i | input | 32 | PLL parameter word |
| csel_i | input | 32 | Clock-select word (bus pre-divider field) |
| strap_i | input | 32 | Strap word (reference and preset select) |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse: outputs just updated |
| pll_hz_o | output | 32 | PLL output frequency in Hz |
| bus_hz_o | output | 32 | Bus clock frequency in Hz |

## Verification
Two events can fall in the same cycle: the publication of a result and the acceptance of the next start. The bench provokes this by watching `done_o` and raising `start_i` for the same clock cycle, so the finishing job and the new one meet at one edge. The bench judges the result in three ways. The published frequencies must belong to the earlier words. `busy_o` must rise on the next cycle. The second job's later result must match the second set of words. A start raised in the middle of a job is also used, to check that the running result is not disturbed.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

    localparam int WORD_W = 32;

    // reference frequencies
    localparam logic [WORD_W-1:0] REF_24M = 32'd24_000_000;
    localparam logic [WORD_W-1:0] REF_25M = 32'd25_000_000;
    localparam logic [WORD_W-1:0] REF_48M = 32'd48_000_000;
    localparam logic [WORD_W-1:0] MHZ     = 32'd1_000_000;

    // strap word positions
    localparam int STRAP_25M_BIT = 23;
    localparam int STRAP_48M_BIT = 18;
    localparam int STRAP_SEL_LSB = 8;
    localparam int STRAP_SEL_W   = 2;

    // clock-select divider field
    localparam int CSEL_DIV_LSB = 23;
    localparam int CSEL_DIV_W   = 3;

    // current layout control bits
    localparam int CUR_OFF_BIT = 23;
    localparam int CUR_BYP_BIT = 20;

    // legacy layout control bits
    localparam int LEG_OFF_BIT  = 18;
    localparam int LEG_BYP_BIT  = 17;
    localparam int LEG_PROG_BIT = 19;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WAIT_A,
        ST_WAIT_B,
        ST_MUL,
        ST_BUSDIV,
        ST_WAIT_C
    } calc_state_e;

    typedef struct packed {
        logic       off;
        logic       bypass;
        logic       programmed;
        logic [5:0] p;
        logic [7:0] m;
        logic [4:0] n;
        logic [5:0] ln;
        logic       od;
        logic [3:0] d;
    } pll_fields_t;

    function automatic pll_fields_t unpack_param(input logic [WORD_W-1:0] w,
                                                 input bit legacy);
        pll_fields_t f;
        f.off        = legacy ? w[LEG_OFF_BIT] : w[CUR_OFF_BIT];
        f.bypass     = legacy ? w[LEG_BYP_BIT] : w[CUR_BYP_BIT];
        f.programmed = legacy ? w[LEG_PROG_BIT] : 1'b1;
        f.p          = w[18:13];
        f.m          = w[12:5];
        f.n          = w[4:0];
        f.ln         = w[10:5];
        f.od         = w[4];
        f.d          = w[3:0];
        return f;
    endfunction

    function automatic logic [9:0] preset_mhz(input logic [STRAP_SEL_W-1:0] sel,
                                              input logic row25);
        logic [9:0] v;
        case (sel)
            2'd0:    v = row25 ? 10'd400 : 10'd384;
            2'd1:    v = row25 ? 10'd375 : 10'd360;
            2'd2:    v = row25 ? 10'd350 : 10'd336;
            default: v = row25 ? 10'd425 : 10'd408;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pll_ref_select.sv
module pll_ref_select
    import pll_calc_pkg::*;
(
    input  logic [WORD_W-1:0] strap_i,
    output logic [WORD_W-1:0] ref_hz_o,
    output logic [WORD_W-1:0] preset_hz_o
);
    logic [9:0] mhz;

    always_comb begin
        if (strap_i[STRAP_25M_BIT])
            ref_hz_o = REF_25M;
        else if (strap_i[STRAP_48M_BIT])
            ref_hz_o = REF_48M;
        else
            ref_hz_o = REF_24M;
    end

    assign mhz         = preset_mhz(strap_i[STRAP_SEL_LSB +: STRAP_SEL_W],
                                    strap_i[STRAP_25M_BIT]);
    assign preset_hz_o = WORD_W'(mhz) * MHZ;

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quotient_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       shifted;
    logic [W:0]       diff;
    logic             fits;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = shifted >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q  <= '0;
                quo_q  <= dividend_i;
                dvs_q  <= divisor_i;
                cnt_q  <= CNT_W'(W);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem_q <= fits ? diff : shifted;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quotient_o = quo_q;

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pll_calc_pkg::*;
#(
    parameter bit LEGACY_FMT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] param_i,
    input  logic [WORD_W-1:0] csel_i,
    input  logic [WORD_W-1:0] strap_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] pll_hz_o,
    output logic [WORD_W-1:0] bus_hz_o
);
    localparam int BUS_SHIFT = LEGACY_FMT ? 1 : 2;

    calc_state_e           state_q;
    pll_fields_t           fld_q;
    logic [CSEL_DIV_W-1:0] cdiv_q;
    logic [WORD_W-1:0]     ref_q;
    logic [WORD_W-1:0]     preset_q;
    logic [WORD_W-1:0]     mult_q;
    logic [WORD_W-1:0]     freq_q;
    logic                  div_start;
    logic [WORD_W-1:0]     div_a;
    logic [WORD_W-1:0]     div_b;

    logic [WORD_W-1:0]     ref_hz;
    logic [WORD_W-1:0]     preset_hz;
    logic                  div_busy;
    logic                  div_done;
    logic [WORD_W-1:0]     div_q;

    pll_ref_select u_ref (
        .strap_i     (strap_i),
        .ref_hz_o    (ref_hz),
        .preset_hz_o (preset_hz)
    );

    pll_seq_div #(.W(WORD_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .start_i    (div_start),
        .dividend_i (div_a),
        .divisor_i  (div_b),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .quotient_o (div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fld_q     <= '0;
            cdiv_q    <= '0;
            ref_q     <= '0;
            preset_q  <= '0;
            mult_q    <= '0;
            freq_q    <= '0;
            div_start <= 1'b0;
            div_a     <= '0;
            div_b     <= '0;
            done_o    <= 1'b0;
            pll_hz_o  <= '0;
            bus_hz_o  <= '0;
        end else begin
            done_o    <= 1'b0;
            div_start <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        fld_q    <= unpack_param(param_i, LEGACY_FMT);
                        cdiv_q   <= csel_i[CSEL_DIV_LSB +: CSEL_DIV_W];
                        ref_q    <= ref_hz;
                        preset_q <= preset_hz;
                        state_q  <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (fld_q.off) begin
                        freq_q  <= '0;
                        state_q <= ST_BUSDIV;
                    end else if (!fld_q.programmed) begin
                        freq_q  <= preset_q;
                        state_q <= ST_BUSDIV;
                    end else if (fld_q.bypass) begin
                        mult_q  <= WORD_W'(1);
                        state_q <= ST_MUL;
                    end else begin
                        div_start <= 1'b1;
                        if (LEGACY_FMT) begin
                            div_a <= WORD_W'(fld_q.ln) + WORD_W'(2);
                            div_b <= WORD_W'(fld_q.d) + WORD_W'(1);
                        end else begin
                            div_a <= WORD_W'(fld_q.m) + WORD_W'(1);
                            div_b <= WORD_W'(fld_q.n) + WORD_W'(1);
                        end
                        state_q <= ST_WAIT_A;
                    end
                end
                ST_WAIT_A: begin
                    if (div_done) begin
                        if (LEGACY_FMT) begin
                            mult_q  <= fld_q.od ? div_q : (div_q << 1);
                            state_q <= ST_MUL;
                        end else begin
                            div_start <= 1'b1;
                            div_a     <= div_q;
                            div_b     <= WORD_W'(fld_q.p) + WORD_W'(1);
                            state_q   <= ST_WAIT_B;
                        end
                    end
                end
                ST_WAIT_B: begin
                    if (div_done) begin
                        mult_q  <= div_q;
                        state_q <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    freq_q  <= ref_q * mult_q;
                    state_q <= ST_BUSDIV;
                end
                ST_BUSDIV: begin
                    div_start <= 1'b1;
                    div_a     <= freq_q;
                    div_b     <= WORD_W'(cdiv_q) + WORD_W'(1);
                    state_q   <= ST_WAIT_C;
                end
                ST_WAIT_C: begin
                    if (div_done) begin
                        pll_hz_o <= freq_q;
                        bus_hz_o <= div_q >> BUS_SHIFT;
                        done_o   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk
    import pll_calc_pkg::*;
#(
    parameter bit LEGACY_FMT = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [WORD_W-1:0] param_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [WORD_W-1:0] pll_hz_o,
    input logic [WORD_W-1:0] bus_hz_o
);
    localparam int OFF_BIT   = LEGACY_FMT ? LEG_OFF_BIT : CUR_OFF_BIT;
    localparam int BUS_SHIFT = LEGACY_FMT ? 1 : 2;

    logic cap_off;

    always_ff @(posedge clk) begin
        if (rst)
            cap_off <= 1'b0;
        else if (start_i && !busy_o)
            cap_off <= param_i[OFF_BIT];
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    busy_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(pll_hz_o) && $stable(bus_hz_o)));

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && cap_off) |-> (pll_hz_o == '0 && bus_hz_o == '0));

    // R7
    bus_le_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (bus_hz_o <= (pll_hz_o >> BUS_SHIFT)));

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

endmodule

bind pll_freq_calc pll_freq_calc_chk #(.LEGACY_FMT(LEGACY_FMT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .param_i  (param_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .pll_hz_o (pll_hz_o),
    .bus_hz_o (bus_hz_o)
);

// File: tb/pll_freq_calc_tb.sv
module pll_freq_calc_tb;

    typedef struct {
        longint pll;
        longint bus;
        string  tag;
    } job_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] param = '0;
    logic [31:0] csel = '0;
    logic [31:0] strap = '0;

    logic        busy0, done0, busy1, done1;
    logic [31:0] pll0, bus0, pll1, bus1;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;

    job_t   q0[$];
    job_t   q1[$];
    longint held_pll[2];
    longint held_bus[2];
    bit     prev_done[2];

    always #5 clk = ~clk;

    pll_freq_calc #(.LEGACY_FMT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .param_i(param),
        .csel_i(csel), .strap_i(strap), .busy_o(busy0), .done_o(done0),
        .pll_hz_o(pll0), .bus_hz_o(bus0)
    );

    pll_freq_calc #(.LEGACY_FMT(1'b1)) u_dut_leg (
        .clk(clk), .rst(rst), .start_i(start), .param_i(param),
        .csel_i(csel), .strap_i(strap), .busy_o(busy1), .done_o(done1),
        .pll_hz_o(pll1), .bus_hz_o(bus1)
    );

    function automatic job_t model(input logic [31:0] prm, input logic [31:0] cs,
                                   input logic [31:0] st, input bit leg,
                                   input string tag);
        job_t   j;
        longint rf, mult, pll;
        int     presets[8];
        presets = '{384, 360, 336, 408, 400, 375, 350, 425};
        // R1 reference priority
        rf = st[23] ? 25000000 : (st[18] ? 48000000 : 24000000);
        if (leg ? prm[18] : prm[23]) begin
            pll = 0;                                         // R2
        end else if (leg && !prm[19]) begin
            pll = longint'(presets[{st[23], st[9:8]}]) * 1000000;  // R4
        end else begin
            if (leg ? prm[17] : prm[20])
                mult = 1;
            else if (leg)
                mult = (2 - longint'(prm[4])) *
                       ((longint'(prm[10:5]) + 2) / (longint'(prm[3:0]) + 1));   // R5
            else
                mult = ((longint'(prm[12:5]) + 1) / (longint'(prm[4:0]) + 1)) /
                       (longint'(prm[18:13]) + 1);           // R3
            pll = (rf * mult) & 64'hFFFF_FFFF;               // R6
        end
        j.pll = pll;
        j.bus = (pll / (longint'(cs[25:23]) + 1)) / (leg ? 2 : 4);  // R7
        j.tag = tag;
        return j;
    endfunction

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic watch_unit(input int u, input logic dn, input logic bz,
                              input logic [31:0] p, input logic [31:0] b);
        job_t j;
        if (dn) begin
            check("R8", "done while busy", longint'(bz), 0);
            check("R8", "done lasted two cycles", longint'(prev_done[u]), 0);
            if ((u == 0 ? q0.size() : q1.size()) == 0) begin
                check("R8", "done with no job pending", 1, 0);
            end else begin
                j = (u == 0) ? q0.pop_front() : q1.pop_front();
                held_pll[u] = j.pll;
                held_bus[u] = j.bus;
                check(j.tag, $sformatf("unit%0d pll_hz", u), longint'(p), j.pll);
                check(j.tag, $sformatf("unit%0d bus_hz", u), longint'(b), j.bus);
            end
        end else begin
            // R10 outputs hold between completions
            check("R10", $sformatf("unit%0d pll held", u), longint'(p), held_pll[u]);
            check("R10", $sformatf("unit%0d bus held", u), longint'(b), held_bus[u]);
        end
        prev_done[u] = dn;
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            watch_unit(0, done0, busy0, pll0, bus0);
            watch_unit(1, done1, busy1, pll1, bus1);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            mismatched++;
            compared++;
            $display("FAIL R8: watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // called at a negedge; pulses start for one cycle
    task automatic pulse(input logic [31:0] prm, input logic [31:0] cs,
                         input logic [31:0] st, input string tag);
        param = prm;
        csel  = cs;
        strap = st;
        start = 1'b1;
        if (!busy0) q0.push_back(model(prm, cs, st, 1'b0, tag));
        if (!busy1) q1.push_back(model(prm, cs, st, 1'b1, tag));
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy0 || busy1 || q0.size() != 0 || q1.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic job(input logic [31:0] prm, input logic [31:0] cs,
                       input logic [31:0] st, input string tag);
        pulse(prm, cs, st, tag);
        wait_idle();
    endtask

    initial begin
        held_pll = '{0, 0};
        held_bus = '{0, 0};
        prev_done = '{0, 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10", "pll after reset", longint'(pll0) + longint'(pll1), 0);
        check("R10", "bus after reset", longint'(bus0) + longint'(bus1), 0);
        check("R10", "busy after reset", longint'(busy0 | busy1), 0);
        check("R10", "done after reset", longint'(done0 | done1), 0);

        // R1 reference priority: none, 48, 25, both
        job(32'h0000_0000, 32'h0, 32'h0000_0000, "R1");
        job(32'h0000_0000, 32'h0, 32'h0004_0000, "R1");
        job(32'h0000_0000, 32'h0, 32'h0080_0000, "R1");
        job(32'h0000_0000, 32'h0, 32'h0084_0000, "R1");
        // R3 current formula with truncation
        job({13'd0, 6'd1, 8'd149, 5'd3}, 32'h0180_0000, 32'h0080_0000, "R3");
        job({13'd0, 6'd2, 8'd200, 5'd6}, 32'h0000_0000, 32'h0000_0000, "R3");
        job({13'd0, 6'd0, 8'd2, 5'd9}, 32'h0000_0000, 32'h0000_0000, "R3");
        job(32'h0010_0000 | {13'd0, 6'd3, 8'd90, 5'd1}, 32'h0, 32'h0004_0000, "R3");
        // R2 off bits in both layouts
        job(32'h0080_0000 | {13'd0, 6'd0, 8'd50, 5'd1}, 32'h0100_0000, 32'h0, "R2");
        job(32'h0004_0000 | 32'h0008_0000 | 32'h0000_0123, 32'h0, 32'h0, "R2");
        // R4 legacy presets over every index and both rows
        for (int s = 0; s < 8; s++)
            job(32'h0000_0000, 32'h0080_0000,
                (s >= 4 ? 32'h0080_0000 : 32'h0004_0000) | (32'(s % 4) << 8), "R4");
        // R5 legacy programmed
        job(32'h0008_0000 | {21'd0, 6'd30, 1'b0, 4'd2}, 32'h0, 32'h0, "R5");
        job(32'h0008_0000 | {21'd0, 6'd63, 1'b1, 4'd15}, 32'h0200_0000, 32'h0080_0000, "R5");
        job(32'h0008_0000 | 32'h0002_0000 | 32'h0000_07FF, 32'h0, 32'h0004_0000, "R5");
        // R6 product wraps at 32 bits
        job({13'd0, 6'd0, 8'd255, 5'd0}, 32'h0380_0000, 32'h0004_0000, "R6");
        // R7 every bus pre-divider value
        for (int k = 0; k < 8; k++)
            job({13'd0, 6'd0, 8'd31, 5'd1}, 32'(k) << 23, 32'h0, "R7");

        // R9 start while busy is ignored
        pulse({13'd0, 6'd0, 8'd99, 5'd4}, 32'h0080_0000, 32'h0080_0000, "R9");
        repeat (4) @(negedge clk);
        pulse(32'h0080_0000 | 32'h0004_0000, 32'h0300_0000, 32'h0004_0000, "R9");
        wait_idle();

        // R11 start in the done cycle of unit 0
        pulse({13'd0, 6'd1, 8'd120, 5'd2}, 32'h0, 32'h0, "R11");
        while (!done0) @(negedge clk);
        pulse({13'd0, 6'd0, 8'd10, 5'd0}, 32'h0100_0000, 32'h0080_0000, "R11");
        check("R11", "busy after start in done cycle", longint'(busy0), 1);
        wait_idle();

        // mixed patterns
        for (int i = 0; i < 40; i++)
            job($urandom, $urandom, $urandom, "R6");

        wait_idle();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule